// File: doc/BRIEF.md
# Interrupt Aggregator with Direct Mode

This block gathers peripheral interrupt sources into a bank of groups, up to 32 sources per group. Each source is resynchronised, edge-detected and latched into a per-group status word. Software clears status bits by writing ones. It opens and closes the mask through two separate write ports, one that only sets enable bits and one that only clears them. A read-only result word per group shows which latched events are currently unmasked (status AND enable).

A single global routing bit selects how results leave the block. With the bit at 1, every result bit of every group drives its own interrupt line on `irq_direct`. With the bit at 0, the result bits of a group are OR-reduced into one line per group on `irq_group`, indexed by group number. A source is therefore named by its group number and its bit position inside that group.

Software reaches the block over a plain register bus with byte addresses. Group `g` occupies five words starting at `g*20`: status at +0, set-enable at +4, clear-enable at +8, result at +12, and a reserved word at +16. The routing control word sits at `NUM_GROUPS*20`, and its bit 0 is the direct-mode bit. For the default of 4 groups that address is 80. Reads are registered, and writes take effect at the clock edge that samples them. Because the bus has no back-pressure, a read always completes in one cycle. There is no ready signal, and `bus_rd_valid` marks the returned word.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status bit, every enable bit and the direct-mode bit are 0, and both `irq_direct` and `irq_group` are all zero.
- R2: A rising edge on `src_in[g*32+b]` sets status bit b of group g at the third rising clock edge after the input changes. An input that stays high sets the bit only once, so after it is cleared the bit stays 0.
- R3: A write to the status word (offset +0) clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R4: A write to the set-enable word (offset +4) sets each enable bit whose data bit is 1, and data bits of 0 leave the mask unchanged. Reading offset +4 returns the current mask.
- R5: A write to the clear-enable word (offset +8) clears each enable bit whose data bit is 1, and data bits of 0 leave the mask unchanged. Reading offset +8 also returns the current mask.
- R6: Reading the result word (offset +12) returns status AND enable, and writes to that word change nothing.
- R7: The control word at `NUM_GROUPS*20` holds the direct-mode bit in bit 0 and reads back its value. With the bit at 1, `irq_direct[g*32+b]` equals result bit b of group g and `irq_group` is all zero.
- R8: With the direct-mode bit at 0, `irq_group[g]` is the OR of all result bits of group g and `irq_direct` is all zero.
- R9: A source edge that sets a status bit in the same cycle as a write of 1 that clears that bit leaves the bit set.
- R10: The reserved word (offset +16) and unmapped addresses read as 0, and writes to them change no status, enable or control state.
- R11: A read request returns its data on `bus_rdata` one cycle later, with `bus_rd_valid` high for exactly that cycle. `bus_rd_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_GROUPS*SRC_PER_GROUP | Asynchronous interrupt sources, bit g*SRC_PER_GROUP+b is group g bit b |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | Read data valid, one cycle after bus_rd_en |
| irq_direct | output | NUM_GROUPS*SRC_PER_GROUP | Per-bit interrupt lines in direct mode |
| irq_group | output | NUM_GROUPS | Per-group OR-reduced lines in aggregated mode |

## Verification
If a status or enable bit holds the wrong value, the interrupt lines show it directly, because they follow the registers with no pipeline. A bad bit appears on `irq_direct` or `irq_group` in the cycle after the write or edge that should have set it. The same error shows in the next register read one cycle after the request. A lost edge from the synchroniser shows only after its three-edge latency, so every edge check waits longer than that before reading. A wrong routing choice makes the inactive output port non-zero, and that is visible as soon as the control write lands.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int GROUP_STRIDE = 20;
  localparam int OFS_STATUS   = 0;
  localparam int OFS_SET_EN   = 4;
  localparam int OFS_CLR_EN   = 8;
  localparam int OFS_RESULT   = 12;
  localparam int OFS_RSVD     = 16;
  localparam int BUS_DATA_W   = 32;

  typedef struct packed {
    logic wr_status;
    logic wr_set;
    logic wr_clr;
  } grp_wr_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irq_group_regs.sv
module irq_group_regs
  import irq_agg_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise,
  input  grp_wr_t          wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] status,
  output logic [WIDTH-1:0] enable
);
  logic [WIDTH-1:0] clr_mask;

  assign clr_mask = wr.wr_status ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_mask) | rise;
      if (wr.wr_set)
        enable <= enable | wdata;
      else if (wr.wr_clr)
        enable <= enable & ~wdata;
    end
  end

  // R2 R9
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & $past(rise)) == $past(rise)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.wr_status |=> ((status & $past(wdata) & ~$past(rise)) == '0));

  // R4
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.wr_set |=> ((enable & $past(wdata)) == $past(wdata)));

  // R5
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.wr_clr |=> ((enable & $past(wdata)) == '0));

  // R4 R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr.wr_set || wr.wr_clr) |=> $stable(enable));
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_GROUPS = 4,
  parameter int WIDTH      = 32
) (
  input  logic                        direct_mode,
  input  logic [NUM_GROUPS*WIDTH-1:0] result,
  output logic [NUM_GROUPS*WIDTH-1:0] irq_direct,
  output logic [NUM_GROUPS-1:0]       irq_group
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_route
    logic [WIDTH-1:0] grp_res;
    assign grp_res = result[g*WIDTH +: WIDTH];
    assign irq_direct[g*WIDTH +: WIDTH] = direct_mode ? grp_res : '0;
    assign irq_group[g] = !direct_mode && (|grp_res);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_GROUPS    = 4,
  parameter int SRC_PER_GROUP = 32,
  parameter int ADDR_W        = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] src_in,
  input  logic                                bus_wr_en,
  input  logic                                bus_rd_en,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [BUS_DATA_W-1:0]               bus_wdata,
  output logic [BUS_DATA_W-1:0]               bus_rdata,
  output logic                                bus_rd_valid,
  output logic [NUM_GROUPS*SRC_PER_GROUP-1:0] irq_direct,
  output logic [NUM_GROUPS-1:0]               irq_group
);
  localparam int W         = SRC_PER_GROUP;
  localparam int TOTAL     = NUM_GROUPS * W;
  localparam int CTRL_ADDR = NUM_GROUPS * GROUP_STRIDE;

  logic [TOTAL-1:0]           rise;
  logic [NUM_GROUPS-1:0][W-1:0] status_q, enable_q;
  logic [TOTAL-1:0]           result_flat;
  logic                       direct_mode;
  logic                       ctrl_wr;
  logic [BUS_DATA_W-1:0]      rd_next;

  irq_edge_sync #(.WIDTH(TOTAL)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(src_in), .rise(rise)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int BASE = g * GROUP_STRIDE;
    grp_wr_t wr;
    assign wr.wr_status = bus_wr_en && (bus_addr == ADDR_W'(BASE + OFS_STATUS));
    assign wr.wr_set    = bus_wr_en && (bus_addr == ADDR_W'(BASE + OFS_SET_EN));
    assign wr.wr_clr    = bus_wr_en && (bus_addr == ADDR_W'(BASE + OFS_CLR_EN));

    irq_group_regs #(.WIDTH(W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .rise(rise[g*W +: W]),
      .wr(wr),
      .wdata(bus_wdata[W-1:0]),
      .status(status_q[g]),
      .enable(enable_q[g])
    );
    assign result_flat[g*W +: W] = status_q[g] & enable_q[g];
  end

  assign ctrl_wr = bus_wr_en && (bus_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) direct_mode <= 1'b0;
    else if (ctrl_wr) direct_mode <= bus_wdata[0];
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (bus_addr == ADDR_W'(g*GROUP_STRIDE + OFS_STATUS))
        rd_next[W-1:0] = status_q[g];
      if (bus_addr == ADDR_W'(g*GROUP_STRIDE + OFS_SET_EN) ||
          bus_addr == ADDR_W'(g*GROUP_STRIDE + OFS_CLR_EN))
        rd_next[W-1:0] = enable_q[g];
      if (bus_addr == ADDR_W'(g*GROUP_STRIDE + OFS_RESULT))
        rd_next[W-1:0] = status_q[g] & enable_q[g];
    end
    if (bus_addr == ADDR_W'(CTRL_ADDR))
      rd_next[0] = direct_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      bus_rd_valid <= 1'b0;
    end else begin
      bus_rd_valid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_next;
    end
  end

  irq_route #(.NUM_GROUPS(NUM_GROUPS), .WIDTH(W)) u_route (
    .direct_mode(direct_mode),
    .result(result_flat),
    .irq_direct(irq_direct),
    .irq_group(irq_group)
  );

  // R7
  direct_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_mode |-> (irq_direct == result_flat && irq_group == '0));

  // R8
  group_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_mode |-> (irq_direct == '0 && (|irq_group) == (|result_flat)));

  // R7
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (direct_mode == $past(bus_wdata[0])));

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rd_valid);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rd_valid);

  // R10
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == ADDR_W'(OFS_RSVD)) |=> (bus_rdata == '0));
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  localparam int NG = 4;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int T  = NG * W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [T-1:0]  src;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          rd_valid;
  logic [T-1:0]  irq_direct;
  logic [NG-1:0] irq_group;

  irq_aggregator #(.NUM_GROUPS(NG), .SRC_PER_GROUP(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src),
    .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rd_valid(rd_valid),
    .irq_direct(irq_direct), .irq_group(irq_group)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(string tag, logic [T-1:0] act, logic [T-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(int a, logic [31:0] e, string tag);
    exp_t it;
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(int idx);
    @(negedge clk); src[idx] = 1'b1;
    repeat (4) @(negedge clk);
    src[idx] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (sbq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", rdata);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        chk(it.tag, T'(rdata), T'(it.exp));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_direct", irq_direct, '0);
    chk("R1 irq_group", T'(irq_group), '0);
    chk("R11 idle valid", T'(rd_valid), '0);
    bus_rd(0,  32'h0, "R1 status");
    bus_rd(4,  32'h0, "R1 enable");
    bus_rd(80, 32'h0, "R1 ctrl");

    // R2 edge latch in two groups
    pulse(3);
    pulse(2*W + 31);
    bus_rd(0,  32'h0000_0008, "R2 g0 status");
    bus_rd(40, 32'h8000_0000, "R2 g2 status");
    bus_rd(12, 32'h0, "R6 result masked");
    chk("R8 group masked", T'(irq_group), '0);

    // R4 set-enable
    bus_wr(4, 32'h9);
    bus_rd(4, 32'h9, "R4 set readback");
    bus_rd(8, 32'h9, "R5 clr readback");
    bus_wr(4, 32'h0);
    bus_rd(4, 32'h9, "R4 zero write");
    bus_rd(12, 32'h8, "R6 result");
    chk("R8 group g0", T'(irq_group), T'(4'b0001));
    chk("R8 direct idle", irq_direct, '0);
    bus_wr(44, 32'h8000_0000);
    chk("R8 group g0 g2", T'(irq_group), T'(4'b0101));

    // R7 direct mode
    bus_wr(80, 32'h1);
    bus_rd(80, 32'h1, "R7 ctrl readback");
    chk("R7 direct lines", irq_direct, (T'(1) << 3) | (T'(1) << (2*W + 31)));
    chk("R7 group idle", T'(irq_group), '0);

    // R6 result read-only
    bus_wr(12, 32'hFFFF_FFFF);
    bus_rd(12, 32'h8, "R6 read-only");

    // R3 write-one-to-clear
    bus_wr(0, 32'h0);
    bus_rd(0, 32'h8, "R3 zero write");
    bus_wr(0, 32'h8);
    bus_rd(0, 32'h0, "R3 cleared");
    chk("R7 after clear", irq_direct, T'(1) << (2*W + 31));

    // R5 clear-enable
    bus_wr(8, 32'h1);
    bus_rd(4, 32'h8, "R5 cleared bit");
    bus_wr(8, 32'h0);
    bus_rd(8, 32'h8, "R5 zero write");

    // R2 level held sets only once
    @(negedge clk); src[W + 7] = 1'b1;
    repeat (5) @(negedge clk);
    bus_rd(20, 32'h80, "R2 held level set");
    bus_wr(20, 32'h80);
    repeat (5) @(negedge clk);
    bus_rd(20, 32'h0, "R2 held level no reset");
    src[W + 7] = 1'b0;

    // R9 edge coincides with clear
    pulse(5);
    @(negedge clk); src[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = AW'(0); wdata = 32'h20; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    bus_rd(0, 32'h20, "R9 set wins");
    bus_wr(0, 32'h20);
    bus_rd(0, 32'h0, "R3 later clear");
    src[5] = 1'b0;

    // R10 reserved and unmapped
    bus_rd(16, 32'h0, "R10 reserved read");
    bus_wr(16, 32'hFFFF_FFFF);
    bus_rd(16, 32'h0, "R10 reserved after write");
    bus_wr(252, 32'hFFFF_FFFF);
    bus_rd(252, 32'h0, "R10 unmapped read");
    bus_rd(4, 32'h8, "R10 enable untouched");
    bus_rd(80, 32'h1, "R10 ctrl untouched");

    // R8 back to aggregated mode
    bus_wr(80, 32'h0);
    chk("R8 direct off", irq_direct, '0);
    chk("R8 group g2", T'(irq_group), T'(4'b0100));

    repeat (3) @(negedge clk);
    chk("R11 idle valid end", T'(rd_valid), '0);
    chk("R11 scoreboard drained", T'(sbq.size()), '0);
    finish_run();
  end
endmodule